// File: doc/BRIEF.md
# Late-Resolving Branch Redirect and Flush Controller

This block produces the fetch address and the squash controls for a five-stage in-order pipeline that treats every conditional branch as not taken. Fetch runs down the sequential path with no wait. A conditional branch reaches the execute stage with its two source operands, its incremented PC and its 16-bit offset. The block tests the operands for equality by checking that their difference is zero and forms the branch target. It keeps the outcome and the target in its own execute-to-memory latch. The branch resolves one cycle later, while it sits in the memory stage.

When that branch is taken, the three younger instructions are on the wrong path. These are the ones in fetch/decode, in decode/execute and the one leaving execute. The block raises a flush for all three stages in the same cycle and sends the next fetch to the target. A branch that is not taken costs nothing. An unconditional jump in the decode stage redirects at once and discards only the instruction behind it. A hazard stall from elsewhere holds the PC, but a branch redirect overrides the stall.

All pins are plain control and data. There is no streaming handshake: every input is sampled on each rising clock edge, and the pipeline around the block owns its own stalling.

Top module: `pnt_redirect_unit`

## Requirements
- R1: While reset is low and in the first cycle after it, `fetch_pc` equals the parameter RESET_PC, and `flush_fd`, `flush_de`, `flush_em` and `redirect` are all low.
- R2: With no stall, no jump and no taken branch, `fetch_pc` rises by 4 at every clock edge.
- R3: With `stall` high and no taken branch in the memory stage, `fetch_pc` keeps its value across the edge.
- R4: A branch latched with unequal operands (nonzero difference) causes no flush and no redirect, and the PC keeps advancing by 4 with no lost cycle.
- R5: A branch latched with equal operands raises `flush_fd`, `flush_de`, `flush_em` and `redirect` together, for exactly the one cycle after the edge that latched it.
- R6: The branch target equals `ex_pc4` plus the 16-bit offset sign-extended and shifted left by two; a negative offset moves the target backward.
- R7: On the edge after a taken branch is seen, `fetch_pc` loads the target, even when `stall` is high in that cycle.
- R8: With `id_jump` high, `stall` low and no taken branch, `next_pc` is {upper 4 bits of `id_pc4`, 26-bit `id_index`, 2'b00}. Only `flush_fd` is raised, and `fetch_pc` loads that value on the next edge.
- R9: When a taken branch and a decode-stage jump occur in the same cycle, the branch wins: the PC loads the branch target.
- R10: A branch on `ex_branch` in the cycle a taken branch flushes is wrong-path and is dropped, so no redirect follows from it.
- R11: A decode-stage jump while `stall` is high is ignored: no flush, and the PC holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Hazard stall: hold the PC |
| id_jump | input | 1 | Unconditional jump in the decode stage |
| id_pc4 | input | 32 | Incremented PC of the decode-stage instruction |
| id_index | input | 26 | Jump word index field |
| ex_branch | input | 1 | Conditional branch in the execute stage |
| ex_opa | input | 32 | First branch operand |
| ex_opb | input | 32 | Second branch operand |
| ex_pc4 | input | 32 | Incremented PC of the execute-stage branch |
| ex_offset | input | 16 | Signed branch word offset |
| fetch_pc | output | 32 | Current fetch address |
| next_pc | output | 32 | Address to be fetched after the next edge |
| flush_fd | output | 1 | Squash the fetch/decode latch |
| flush_de | output | 1 | Squash the decode/execute latch |
| flush_em | output | 1 | Squash the instruction entering execute/memory |
| redirect | output | 1 | A taken branch is being serviced |

## Verification
A branch presented on the execute inputs before edge N shows its flushes and `redirect` in the cycle after edge N. The new `fetch_pc` appears after edge N+1. A jump or a stall acts on `next_pc` at once and on `fetch_pc` after the next edge. Inputs are driven on the falling edge, and every check samples on a later falling edge. Each check is placed by counting edges from the stimulus to the due cycle: one edge for flushes, two for a branch's PC, one for a jump's PC. A bench-side PC model supplies the expected addresses.

// File: rtl/pnt_pkg.sv
package pnt_pkg;

  typedef enum logic [1:0] {
    SEL_SEQ    = 2'd0,
    SEL_HOLD   = 2'd1,
    SEL_BRANCH = 2'd2,
    SEL_JUMP   = 2'd3
  } pc_sel_e;

endpackage

// File: rtl/pnt_ex_resolve.sv
module pnt_ex_resolve #(
  parameter int XLEN  = 32,
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             squash,
  input  logic             ex_branch,
  input  logic [XLEN-1:0]  ex_opa,
  input  logic [XLEN-1:0]  ex_opb,
  input  logic [XLEN-1:0]  ex_pc4,
  input  logic [OFS_W-1:0] ex_offset,
  output logic             mem_taken,
  output logic [XLEN-1:0]  mem_target
);
  localparam int EXT_W = XLEN - OFS_W - 2;

  logic [XLEN-1:0] diff;
  logic            diff_zero;
  logic [XLEN-1:0] byte_ofs;
  logic [XLEN-1:0] tgt_calc;
  logic            br_q;
  logic            zero_q;
  logic [XLEN-1:0] tgt_q;

  always_comb begin
    diff      = ex_opa - ex_opb;
    diff_zero = (diff == '0);
    byte_ofs  = {{EXT_W{ex_offset[OFS_W-1]}}, ex_offset, 2'b00};
    tgt_calc  = ex_pc4 + byte_ofs;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      br_q   <= 1'b0;
      zero_q <= 1'b0;
      tgt_q  <= '0;
    end else begin
      br_q   <= ex_branch & ~squash;
      zero_q <= diff_zero;
      tgt_q  <= tgt_calc;
    end
  end

  assign mem_taken  = br_q & zero_q;
  assign mem_target = tgt_q;

  // R10: a squashed execute slot never becomes a taken branch
  assert_squash_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> !mem_taken);

  // R5: a taken branch lasts one cycle since its own flush drops the next slot
  assert_single_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_taken |=> !mem_taken);

endmodule

// File: rtl/pnt_flush_gen.sv
module pnt_flush_gen
  import pnt_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    mem_taken,
  input  logic    id_jump,
  input  logic    stall,
  output pc_sel_e sel,
  output logic    flush_fd,
  output logic    flush_de,
  output logic    flush_em,
  output logic    redirect
);
  logic jump_go;

  always_comb begin
    jump_go  = id_jump & ~stall & ~mem_taken;
    flush_fd = mem_taken | jump_go;
    flush_de = mem_taken;
    flush_em = mem_taken;
    redirect = mem_taken;
    if (mem_taken)    sel = SEL_BRANCH;
    else if (jump_go) sel = SEL_JUMP;
    else if (stall)   sel = SEL_HOLD;
    else              sel = SEL_SEQ;
  end

  // R5: the memory-stage squash always comes with both younger squashes
  assert_flush_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flush_em |-> (flush_fd && flush_de));

  // R11: a stalled jump leaves the fetch/decode latch alone
  assert_stalled_jump_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (id_jump && stall && !mem_taken) |-> !flush_fd);

  // R9: a taken branch always selects the branch target
  assert_branch_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_taken |-> (sel == SEL_BRANCH));

endmodule

// File: rtl/pnt_pc_reg.sv
module pnt_pc_reg
  import pnt_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              JIDX_W   = 26,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pc_sel_e           sel,
  input  logic [XLEN-1:0]   br_target,
  input  logic [XLEN-1:0]   id_pc4,
  input  logic [JIDX_W-1:0] id_index,
  output logic [XLEN-1:0]   pc,
  output logic [XLEN-1:0]   pc_nxt
);
  localparam int HI_W = XLEN - JIDX_W - 2;

  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] jmp_target;

  always_comb begin
    jmp_target = {id_pc4[XLEN-1 -: HI_W], id_index, 2'b00};
    unique case (sel)
      SEL_BRANCH: pc_nxt = br_target;
      SEL_JUMP:   pc_nxt = jmp_target;
      SEL_HOLD:   pc_nxt = pc_q;
      default:    pc_nxt = pc_q + XLEN'(4);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= RESET_PC;
    else        pc_q <= pc_nxt;
  end

  assign pc = pc_q;

  // R2: sequential advance by one word
  assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_SEQ) |=> (pc_q == $past(pc_q) + XLEN'(4)));

  // R3: a stall holds the PC
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_HOLD) |=> $stable(pc_q));

  // R7: a taken branch loads its target on the next edge
  assert_branch_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_BRANCH) |=> (pc_q == $past(br_target)));

endmodule

// File: rtl/pnt_redirect_unit.sv
module pnt_redirect_unit
  import pnt_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              OFS_W    = 16,
  parameter int              JIDX_W   = 26,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              id_jump,
  input  logic [XLEN-1:0]   id_pc4,
  input  logic [JIDX_W-1:0] id_index,
  input  logic              ex_branch,
  input  logic [XLEN-1:0]   ex_opa,
  input  logic [XLEN-1:0]   ex_opb,
  input  logic [XLEN-1:0]   ex_pc4,
  input  logic [OFS_W-1:0]  ex_offset,
  output logic [XLEN-1:0]   fetch_pc,
  output logic [XLEN-1:0]   next_pc,
  output logic              flush_fd,
  output logic              flush_de,
  output logic              flush_em,
  output logic              redirect
);
  logic            mem_taken;
  logic [XLEN-1:0] mem_target;
  pc_sel_e         sel;

  pnt_ex_resolve #(.XLEN(XLEN), .OFS_W(OFS_W)) u_resolve (
    .clk       (clk),
    .rst_n     (rst_n),
    .squash    (flush_em),
    .ex_branch (ex_branch),
    .ex_opa    (ex_opa),
    .ex_opb    (ex_opb),
    .ex_pc4    (ex_pc4),
    .ex_offset (ex_offset),
    .mem_taken (mem_taken),
    .mem_target(mem_target)
  );

  pnt_flush_gen u_flush (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_taken(mem_taken),
    .id_jump  (id_jump),
    .stall    (stall),
    .sel      (sel),
    .flush_fd (flush_fd),
    .flush_de (flush_de),
    .flush_em (flush_em),
    .redirect (redirect)
  );

  pnt_pc_reg #(.XLEN(XLEN), .JIDX_W(JIDX_W), .RESET_PC(RESET_PC)) u_pc (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .br_target(mem_target),
    .id_pc4   (id_pc4),
    .id_index (id_index),
    .pc       (fetch_pc),
    .pc_nxt   (next_pc)
  );

  // R4: a redirect only follows a branch that was offered in the previous cycle
  assert_redirect_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> $past(ex_branch));

endmodule

// File: tb/pnt_redirect_unit_bench.sv
module pnt_redirect_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall = 1'b0;
  logic        id_jump = 1'b0;
  logic [31:0] id_pc4 = '0;
  logic [25:0] id_index = '0;
  logic        ex_branch = 1'b0;
  logic [31:0] ex_opa = '0;
  logic [31:0] ex_opb = '0;
  logic [31:0] ex_pc4 = '0;
  logic [15:0] ex_offset = '0;
  logic [31:0] fetch_pc;
  logic [31:0] next_pc;
  logic        flush_fd, flush_de, flush_em, redirect;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_pc;

  always #5 clk = ~clk;

  pnt_redirect_unit u_pnt_redirect_unit (
    .clk(clk), .rst_n(rst_n), .stall(stall), .id_jump(id_jump),
    .id_pc4(id_pc4), .id_index(id_index), .ex_branch(ex_branch),
    .ex_opa(ex_opa), .ex_opb(ex_opb), .ex_pc4(ex_pc4), .ex_offset(ex_offset),
    .fetch_pc(fetch_pc), .next_pc(next_pc), .flush_fd(flush_fd),
    .flush_de(flush_de), .flush_em(flush_em), .redirect(redirect)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    stall = 0; id_jump = 0; ex_branch = 0;
  endtask

  task automatic offer_branch(input logic [31:0] a, input logic [31:0] b,
                              input logic [31:0] pc4, input logic [15:0] ofs);
    ex_branch = 1; ex_opa = a; ex_opb = b; ex_pc4 = pc4; ex_offset = ofs;
  endtask

  function automatic logic [31:0] br_tgt(input logic [31:0] pc4, input logic [15:0] ofs);
    return pc4 + {{14{ofs[15]}}, ofs, 2'b00};
  endfunction

  task automatic test_reset();
    check("R1 fetch_pc", fetch_pc, 32'h0);
    check("R1 flushes", {28'h0, flush_fd, flush_de, flush_em, redirect}, 32'h0);
    rst_n = 1; tick();
    exp_pc = 32'h4;
    check("R1 first step", fetch_pc, exp_pc);
  endtask

  task automatic test_sequential();
    for (int i = 0; i < 3; i++) begin
      tick(); exp_pc += 4;
      check("R2 advance", fetch_pc, exp_pc);
    end
  endtask

  task automatic test_stall();
    stall = 1; tick(); tick();
    check("R3 hold", fetch_pc, exp_pc);
    idle_inputs(); tick(); exp_pc += 4;
    check("R3 resume", fetch_pc, exp_pc);
  endtask

  task automatic test_not_taken();
    offer_branch(32'h11, 32'h12, 32'h100, 16'h8);
    tick(); exp_pc += 4; idle_inputs();
    check("R4 no flush", {28'h0, flush_fd, flush_de, flush_em, redirect}, 32'h0);
    check("R4 pc", fetch_pc, exp_pc);
    tick(); exp_pc += 4;
    check("R4 no lost cycle", fetch_pc, exp_pc);
  endtask

  task automatic test_taken(input logic [15:0] ofs, input string tag);
    logic [31:0] t;
    t = br_tgt(32'h200, ofs);
    offer_branch(32'hABCD, 32'hABCD, 32'h200, ofs);
    tick(); exp_pc += 4; idle_inputs();
    check("R5 all flush", {28'h0, flush_fd, flush_de, flush_em, redirect}, 32'hF);
    check({tag, " target"}, next_pc, t);
    tick(); exp_pc = t;
    check("R7 pc load", fetch_pc, exp_pc);
    check("R5 one cycle", {28'h0, flush_fd, flush_de, flush_em, redirect}, 32'h0);
  endtask

  task automatic test_branch_over_stall_and_jump();
    logic [31:0] t;
    t = br_tgt(32'h300, 16'h10);
    offer_branch(32'h5, 32'h5, 32'h300, 16'h10);
    tick(); idle_inputs();
    stall = 1; id_jump = 1; id_pc4 = 32'hF000_0000; id_index = 26'h3;
    tick(); exp_pc = t;
    check("R7 R9 branch wins", fetch_pc, exp_pc);
    idle_inputs();
  endtask

  task automatic test_wrong_path_drop();
    logic [31:0] t;
    t = br_tgt(32'h400, 16'h4);
    offer_branch(32'h9, 32'h9, 32'h400, 16'h4);
    tick();
    offer_branch(32'h7, 32'h7, 32'h800, 16'h40);
    tick(); exp_pc = t; idle_inputs();
    check("R10 no redirect", {31'h0, redirect}, 32'h0);
    tick(); exp_pc += 4;
    check("R10 pc", fetch_pc, exp_pc);
  endtask

  task automatic test_jump();
    id_jump = 1; id_pc4 = 32'hA000_0010; id_index = 26'h12_3456;
    #1;
    check("R8 next_pc", next_pc, {4'hA, 26'h12_3456, 2'b00});
    check("R8 flush only fd", {28'h0, flush_fd, flush_de, flush_em, redirect}, 32'h8);
    tick(); idle_inputs(); exp_pc = {4'hA, 26'h12_3456, 2'b00};
    check("R8 pc", fetch_pc, exp_pc);
  endtask

  task automatic test_stalled_jump();
    stall = 1; id_jump = 1; id_index = 26'h1;
    #1;
    check("R11 no flush", {31'h0, flush_fd}, 32'h0);
    tick(); idle_inputs();
    check("R11 hold", fetch_pc, exp_pc);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    test_reset();
    test_sequential();
    test_stall();
    test_not_taken();
    test_taken(16'h0020, "R6 fwd");
    test_taken(16'hFFF0, "R6 back");
    test_branch_over_stall_and_jump();
    test_wrong_path_drop();
    test_jump();
    test_stalled_jump();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule